// File: doc/BRIEF.md
# Tagged Word Frame Reassembler

This block sits on the read side of a FIFO that carries snapshots of sixteen 32-bit channel counters. Each snapshot, 512 bits in all, travels as 32 tagged words. The upper half of a word is a 16-bit slice of the snapshot and the lower half is the number of that slice. The block pulls words from the FIFO whenever it holds data. It checks each tag against the slice it expects next and drops the 16-bit payload into the matching slot of a staging register. When the final slice arrives in order, it publishes the whole snapshot.

Slice numbering drives the reassembly, so the block does not shift words in blindly. A slice number of zero always starts a fresh snapshot. A slice that arrives out of order throws the partial snapshot away and latches an error that stays set until reset. The published snapshot stays on the output until a later snapshot completes cleanly, so no partial or aborted snapshot ever reaches it.

Top module: `frameReassembler`

## Requirements
- R1: `fifoRdEn` is high in exactly the cycles in which `fifoEmpty` is low and `rst` is low.
- R2: The word on `fifoData` is taken in the cycle after the one in which `fifoRdEn` was high. After the slice numbered 31 is taken in order, `frameValid` and the new `frameData` appear in the next cycle.
- R3: A word carries its payload in bits [31:16] and its slice number in bits [15:0]. The payload of slice k lands in `frameData` bits [16k+15:16k], so channel c has its low half in slice 2c and its high half in slice 2c+1.
- R4: A word with slice number 0 starts a new snapshot in any state. Parts gathered before it are discarded and no error is raised.
- R5: A word with a non-zero slice number other than the one expected next sets `seqError`. This includes any non-zero slice number when no snapshot is open. The partial snapshot is then dropped, words are ignored until the next slice 0, and `seqError` stays high until reset.
- R6: A slice number above 31 is treated as out of order, as in R5.
- R7: `frameValid` is high for exactly one cycle for each snapshot whose slices 0 to 31 arrived in order.
- R8: `frameData` changes only together with `frameValid` and otherwise holds the last complete snapshot.
- R9: A synchronous active-high `rst` clears `frameData`, `frameValid`, `seqError` and the slice tracking.
- R10: Idle cycles of any length between the words of one snapshot have no effect on its reassembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoData | input | 32 | FIFO read word, valid the cycle after a read |
| fifoRdEn | output | 1 | FIFO read enable |
| frameData | output | 512 | Last complete snapshot |
| frameValid | output | 1 | One-cycle strobe when `frameData` is updated |
| seqError | output | 1 | Sticky slice-order error |

## Verification
`fifoRdEn` follows `fifoEmpty` in the same cycle. A word popped at one rising edge is presented on the data input during the following cycle and is taken at the edge after that. Its effects on `frameValid`, `frameData` and `seqError` are therefore visible two edges after the read enable was seen. The bench has a behavioural FIFO and a reference model that apply each word at exactly that point, and it compares all outputs at every falling edge. The error, restart and out-of-range cases are compared at the same cycle as the ordinary snapshots.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Strobes handed from control to datapath for the word in flight
  typedef struct packed {
    logic restart; // clear earlier slices before this write
    logic load;    // write payload into the selected slot
    logic commit;  // publish merged staging, then clear it
    logic drop;    // discard staging
  } frCtrl_t;

  typedef enum logic {
    FR_IDLE    = 1'b0,
    FR_COLLECT = 1'b1
  } frState_t;
endpackage

// File: rtl/fr_ctrl.sv
module fr_ctrl
  import fr_pkg::*;
#(
  parameter int PARTS = 32,
  parameter int TAG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fifoEmpty,
  input  logic [TAG_W-1:0]         tag,
  output logic                     fifoRdEn,
  output frCtrl_t                  ctrl,
  output logic [$clog2(PARTS)-1:0] partSel,
  output logic                     seqError
);
  localparam int PART_W = $clog2(PARTS);
  localparam logic [PART_W-1:0] LAST_IDX = PART_W'(PARTS - 1);

  frState_t          state;
  logic [PART_W-1:0] expIdx;
  logic              wordValid;
  logic              isStart;
  logic              inSeq;
  logic              isLast;
  logic              isBad;

  // Read whenever data is there; data follows one cycle later
  assign fifoRdEn = !fifoEmpty && !rst;

  always_ff @(posedge clk) begin
    if (rst) wordValid <= 1'b0;
    else     wordValid <= fifoRdEn;
  end

  assign isStart = wordValid && (tag == '0);
  assign inSeq   = wordValid && (tag != '0) && (state == FR_COLLECT)
                   && (tag == TAG_W'(expIdx));
  assign isLast  = inSeq && (expIdx == LAST_IDX);
  assign isBad   = wordValid && !isStart && !inSeq;

  always_comb begin
    ctrl.restart = isStart;
    ctrl.load    = isStart || inSeq;
    ctrl.commit  = isLast;
    ctrl.drop    = isBad;
  end

  assign partSel = tag[PART_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      expIdx   <= '0;
      seqError <= 1'b0;
    end else if (isStart) begin
      state  <= FR_COLLECT;
      expIdx <= PART_W'(1);
    end else if (isLast) begin
      state  <= FR_IDLE;
      expIdx <= '0;
    end else if (inSeq) begin
      expIdx <= expIdx + PART_W'(1);
    end else if (isBad) begin
      state    <= FR_IDLE;
      expIdx   <= '0;
      seqError <= 1'b1;
    end
  end
endmodule

// File: rtl/fr_datapath.sv
module fr_datapath
  import fr_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int PARTS     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  frCtrl_t                       ctrl,
  input  logic [$clog2(PARTS)-1:0]      partSel,
  input  logic [PAYLOAD_W-1:0]          payload,
  output logic [PARTS*PAYLOAD_W-1:0]    frameData,
  output logic                          frameValid
);
  localparam int PART_W  = $clog2(PARTS);
  localparam int FRAME_W = PARTS * PAYLOAD_W;

  logic [PAYLOAD_W-1:0] stagePart [PARTS];
  logic [FRAME_W-1:0]   mergeVec;

  for (genvar p = 0; p < PARTS; p++) begin : g_slot
    logic [PAYLOAD_W-1:0] baseSlice;
    logic                 hit;

    assign baseSlice = ctrl.restart ? '0 : stagePart[p];
    assign hit       = ctrl.load && (partSel == PART_W'(p));
    assign mergeVec[p*PAYLOAD_W +: PAYLOAD_W] = hit ? payload : baseSlice;

    always_ff @(posedge clk) begin
      if (rst || ctrl.drop || ctrl.commit) stagePart[p] <= '0;
      else stagePart[p] <= mergeVec[p*PAYLOAD_W +: PAYLOAD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameData  <= '0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= ctrl.commit;
      if (ctrl.commit) frameData <= mergeVec;
    end
  end
endmodule

// File: rtl/frameReassembler.sv
module frameReassembler
  import fr_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int TAG_W     = 16,
  parameter int PARTS     = 32,
  localparam int WORD_W   = PAYLOAD_W + TAG_W,
  localparam int FRAME_W  = PARTS * PAYLOAD_W,
  localparam int PART_W   = $clog2(PARTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifoEmpty,
  input  logic [WORD_W-1:0]  fifoData,
  output logic               fifoRdEn,
  output logic [FRAME_W-1:0] frameData,
  output logic               frameValid,
  output logic               seqError
);
  frCtrl_t           ctrl;
  logic [PART_W-1:0] partSel;

  fr_ctrl #(.PARTS(PARTS), .TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fifoEmpty(fifoEmpty),
    .tag      (fifoData[TAG_W-1:0]),
    .fifoRdEn (fifoRdEn),
    .ctrl     (ctrl),
    .partSel  (partSel),
    .seqError (seqError)
  );

  fr_datapath #(.PAYLOAD_W(PAYLOAD_W), .PARTS(PARTS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .partSel   (partSel),
    .payload   (fifoData[WORD_W-1:TAG_W]),
    .frameData (frameData),
    .frameValid(frameValid)
  );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int FRAME_W = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               fifoEmpty,
  input logic               fifoRdEn,
  input logic [FRAME_W-1:0] frameData,
  input logic               frameValid,
  input logic               seqError
);
  logic rstD;
  always_ff @(posedge clk) rstD <= rst;

  // R1
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fifoEmpty |-> !fifoRdEn);

  // R2
  load_latency_chk: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> $past(fifoRdEn, 2));

  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    frameValid |=> !frameValid);

  // R8
  hold_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!frameValid && !$past(rst)) |-> $stable(frameData));

  // R5
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    seqError |=> seqError);

  // R9
  always @(negedge clk) begin
    if (rstD === 1'b1)
      reset_clear_chk: assert (frameData == '0 && !frameValid && !seqError);
  end
endmodule

bind frameReassembler fr_checker #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fifoEmpty (fifoEmpty),
  .fifoRdEn  (fifoRdEn),
  .frameData (frameData),
  .frameValid(frameValid),
  .seqError  (seqError)
);

// File: tb/frameReassembler_test.sv
module frameReassembler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPARTS     = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fifoEmpty = 1'b1;
  logic [31:0]  fifoData = '0;
  logic         fifoRdEn;
  logic [511:0] frameData;
  logic         frameValid;
  logic         seqError;

  frameReassembler uut (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoRdEn(fifoRdEn), .frameData(frameData), .frameValid(frameValid),
    .seqError(seqError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // stimulus source: word, idle cycles after it, scenario tag
  logic [31:0] srcWord[$];
  int          srcGap[$];
  string       srcTag[$];
  logic [31:0] fifoQ[$];
  string       scen = "R9 reset";

  // reference model
  logic [15:0]  mStage [NPARTS];
  int           mExp = 0;
  bit           mErr = 0;
  bit           mValid = 0;
  logic [511:0] mFrame = '0;

  task automatic push(input logic [15:0] pl, input int idx, input int gap, input string tg);
    srcWord.push_back({pl, 16'(idx)});
    srcGap.push_back(gap);
    srcTag.push_back(tg);
  endtask

  function automatic logic [15:0] pattern(input int seed, input int k);
    return 16'(seed * 4099 + k * 257 + 3);
  endfunction

  task automatic addFrame(input int seed, input int gapMod, input string tg);
    for (int k = 0; k < NPARTS; k++)
      push(pattern(seed, k), k, (gapMod == 0) ? 0 : (k % gapMod) * 2, tg);
  endtask

  task automatic modelClear();
    for (int k = 0; k < NPARTS; k++) mStage[k] = '0;
  endtask

  task automatic modelApply(input logic [31:0] w);
    int idx;
    idx = int'(w[15:0]);
    if (idx == 0) begin
      modelClear();
      mStage[0] = w[31:16];
      mExp = 1;
    end else if (mExp != 0 && idx == mExp) begin
      mStage[idx] = w[31:16];
      if (idx == NPARTS - 1) begin
        for (int k = 0; k < NPARTS; k++) mFrame[k*16 +: 16] = mStage[k];
        mValid = 1;
        mExp = 0;
        modelClear();
      end else mExp++;
    end else begin
      mErr = 1;
      mExp = 0;
      modelClear();
    end
  endtask

  task automatic cmp1(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, scen, $time, act, exp);
    end
  endtask

  task automatic cmpFrame(input string req);
    compared++;
    if (frameData !== mFrame) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, scen, $time, frameData, mFrame);
    end
  endtask

  initial begin
    bit          presValid = 0;
    logic [31:0] presWord = '0;
    bit          popValid = 0;
    logic [31:0] popWord = '0;
    int          gapCnt = 0;
    int          cyc = 0;
    int          tailCnt = 0;
    bit          newRst;

    // R3 R7: back-to-back snapshot
    addFrame(1, 0, "R3 R7 back-to-back");
    // R10: idle gaps of varying length inside one snapshot
    addFrame(2, 4, "R10 gapped");
    // R4: restart after ten slices, then a full snapshot, no error
    for (int k = 0; k < 10; k++) push(pattern(3, k), k, 0, "R4 restart");
    addFrame(4, 3, "R4 restart");
    // R6: slice number above range aborts
    for (int k = 0; k < 4; k++) push(pattern(5, k), k, 1, "R6 above range");
    push(16'hBEEF, 40, 0, "R6 above range");
    push(16'h1234, 4, 0, "R6 ignored after abort");
    // R5: skipped slice, then stray words including 31, sticky error
    for (int k = 0; k < 5; k++) push(pattern(6, k), k, 0, "R5 skipped");
    push(16'h5555, 6, 0, "R5 skipped");
    push(16'h7777, 7, 2, "R5 ignored");
    push(16'h3131, 31, 0, "R5 stray last");
    // R8: clean snapshot after errors updates output, error stays
    addFrame(7, 5, "R8 recovery");
    push(16'h0101, 1, 0, "R5 non-zero when idle");

    while (!finished) begin
      @(negedge clk);
      cyc++;
      // R1: read enable for the edge just passed
      cmp1("R1 fifoRdEn", fifoRdEn, !fifoEmpty && !rst);
      if (rst) begin
        mExp = 0; mErr = 0; mValid = 0; mFrame = '0;
        modelClear();
        presValid = 0;
      end else begin
        mValid = 0;
        if (presValid) modelApply(presWord);
      end
      // R2 timing: model applies word two edges after its read
      cmp1("R7 frameValid", frameValid, mValid);
      cmp1("R5 seqError", seqError, mErr);
      cmpFrame("R8 frameData");

      // reset plan: 3 cycles at start, 2 cycles after the stream drains
      newRst = (cyc < 3) || (tailCnt >= 8 && tailCnt < 10);
      if (newRst && !rst) scen = "R9 reset";
      rst = newRst;

      presValid = popValid;
      presWord  = popWord;
      if (presValid) fifoData = presWord;

      if (!rst && cyc >= 3) begin
        if (gapCnt > 0) gapCnt--;
        else if (srcWord.size() != 0) begin
          fifoQ.push_back(srcWord.pop_front());
          gapCnt = srcGap.pop_front();
          scen = srcTag.pop_front();
        end
      end

      fifoEmpty = (fifoQ.size() == 0);
      popValid = !fifoEmpty && !rst;
      if (popValid) popWord = fifoQ.pop_front();

      if (cyc > 3 && srcWord.size() == 0 && fifoQ.size() == 0 && !popValid)
        tailCnt++;
      if (tailCnt >= 14) finished = 1;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog [%s] run did not finish", scen);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule